// File: doc/BRIEF.md
# SPI Master with Selectable Receive Sample Point

This block is a single-device SPI master for SPI mode 0. It drives a chip select, a serial clock and a serial data output, and it shifts in the serial data input. Each transfer moves one 8-bit word in each direction, most significant bit first. A transfer begins with a one-cycle `start` pulse and ends with a one-cycle `done` pulse. The received word appears on `rx_data` in the same cycle as that pulse.

The serial clock is derived from the system clock in two steps. A prescaler divides the system clock by P, where P runs from 1 to 8192. The resulting ticks then form the serial clock: a high phase of H ticks followed by a low phase of L ticks, with H and L each from 1 to 64. Every divider field is programmed as its value minus one.

A sample-select bit chooses when the receive data is captured:
- Standard: on the rising serial-clock edge.
- Delayed: on the following falling edge, half a clock period later. This tolerates a slave whose output path is slow compared with the low phase.

Delayed capture is the reset default, and it is forced whenever P is 1. Configuration is taken only while the engine is idle.

Top module: `spi_smp_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, busy is 0, done is 0 and rx_data is 0.
- R2: With fields pre_m1, hi_m1 and lo_m1, define P = pre_m1+1, H = hi_m1+1 and L = lo_m1+1. Each serial-clock high phase then lasts P*H system clocks, and each low phase lasts P*L system clocks.
- R3: cs_n falls P*(H+L) system clocks before the first sclk rising edge. A frame has exactly 8 sclk rising edges, and sclk is low whenever cs_n is high.
- R4: mosi presents tx_data bit 7 first and changes only on sclk falling edges, so a slave sampling on rising edges receives tx_data unchanged.
- R5: With cfg_samp_std = 1 and P >= 2, miso is captured on each sclk rising edge. A slave output delay longer than the low phase therefore returns every bit one position late.
- R6: With cfg_samp_std = 0, miso is captured on the sclk falling edge that follows each rising edge. For bit 0 this is the final falling edge before cs_n rises.
- R7: The sample-select bit resets to 0, so a transfer after reset with no configuration write uses delayed capture. The reset divider is P = 2, H = 1, L = 1.
- R8: When P = 1, capture is delayed whatever cfg_samp_std holds.
- R9: A cfg_we pulse while busy is 1 changes nothing. A cfg_we pulse while idle, including in the same cycle as an accepted start, sets the configuration used by that transfer.
- R10: cs_n rises P*L system clocks after the last sclk falling edge. In that same cycle:
  - done is 1 for exactly one cycle,
  - rx_data takes the received word,
  - busy falls.
- R11: A start pulse while busy is 1 is ignored. Busy stays 1 and no extra transfer or done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe, accepted only when idle |
| cfg_pre_m1 | input | 13 | Prescaler divide minus one |
| cfg_hi_m1 | input | 6 | Serial clock high ticks minus one |
| cfg_lo_m1 | input | 6 | Serial clock low ticks minus one |
| cfg_samp_std | input | 1 | 1: capture on rising edge, 0: capture half a period later |
| start | input | 1 | Transfer request pulse |
| tx_data | input | 8 | Word to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_data | output | 8 | Last received word |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two collisions matter most. The first is a configuration write and an accepted start landing on the same idle edge. The bench provokes it by raising cfg_we and start together with new divider values. It then judges the frame's lead time, high width and tail time against the new values rather than the old ones. The second collision is a start or a configuration write landing inside a running frame. The bench injects each mid-frame and then expects three things: exactly one done, the first word's data, and the previous divider settings on the next transfer. A slave model with a programmable output delay separates the two capture points. At a delay beyond the low phase, standard capture must return the byte shifted one place, while delayed capture must return it intact.

// File: rtl/spi_smp_pkg.sv
package spi_smp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } spi_state_e;

  // Standard-edge capture is honoured only when the prescaler divides by 2+.
  function automatic logic use_std_edge(input logic samp_std, input logic pre_is_one);
    return samp_std & ~pre_is_one;
  endfunction

endpackage

// File: rtl/spi_smp_cfg.sv
module spi_smp_cfg #(
  parameter int PRE_W      = 13,
  parameter int CNT_W      = 6,
  parameter int RST_PRE_M1 = 1,
  parameter int RST_HI_M1  = 0,
  parameter int RST_LO_M1  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             we,
  input  logic [PRE_W-1:0] pre_in,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  input  logic             samp_in,
  output logic [PRE_W-1:0] pre_m1,
  output logic [CNT_W-1:0] hi_m1,
  output logic [CNT_W-1:0] lo_m1,
  output logic             samp_std,
  output logic             accept
);

  assign accept = we & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_m1   <= PRE_W'(RST_PRE_M1);
      hi_m1    <= CNT_W'(RST_HI_M1);
      lo_m1    <= CNT_W'(RST_LO_M1);
      samp_std <= 1'b0;
    end else if (accept) begin
      pre_m1   <= pre_in;
      hi_m1    <= hi_in;
      lo_m1    <= lo_in;
      samp_std <= samp_in;
    end
  end

  // R9: settings frozen while a frame runs
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pre_m1) && $stable(hi_m1) && $stable(lo_m1) && $stable(samp_std)));

endmodule

// File: rtl/spi_smp_tick.sv
module spi_smp_tick #(
  parameter int PRE_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_m1,
  output logic             tick
);

  logic [PRE_W-1:0] pre_cnt;

  assign tick = run && (pre_cnt == pre_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_cnt <= '0;
    else if (!run || tick)  pre_cnt <= '0;
    else                    pre_cnt <= pre_cnt + PRE_W'(1);
  end

  // R2: with a divide of 2 or more, ticks never fall on adjacent cycles
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_m1 != '0) |=> !tick);

endmodule

// File: rtl/spi_smp_shift.sv
module spi_smp_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              use_std,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word,
  output logic              cap
);

  logic [DATA_W-1:0] tx_sh;

  assign mosi = tx_sh[DATA_W-1];
  assign cap  = use_std ? rise_ev : fall_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_sh <= '0;
    else if (load)    tx_sh <= load_data;
    else if (fall_ev) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_word <= '0;
    else if (load) rx_word <= '0;
    else if (cap)  rx_word <= {rx_word[DATA_W-2:0], miso};
  end

  // R4: a load never coincides with a serial clock edge
  assert_load_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!rise_ev && !fall_ev));

  // R5, R6: edge events are exclusive, so one capture per bit
  assert_edges_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_ev, fall_ev}));

endmodule

// File: rtl/spi_smp_master.sv
module spi_smp_master #(
  parameter int DATA_W     = 8,
  parameter int PRE_W      = 13,
  parameter int CNT_W      = 6,
  parameter int RST_PRE_M1 = 1,
  parameter int RST_HI_M1  = 0,
  parameter int RST_LO_M1  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PRE_W-1:0]  cfg_pre_m1,
  input  logic [CNT_W-1:0]  cfg_hi_m1,
  input  logic [CNT_W-1:0]  cfg_lo_m1,
  input  logic              cfg_samp_std,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  import spi_smp_pkg::*;

  localparam int PH_W  = CNT_W + 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  spi_state_e       state;
  logic [PH_W-1:0]  ph_cnt, ph_lim;
  logic [BIT_W-1:0] bit_cnt;
  logic [PRE_W-1:0] pre_m1;
  logic [CNT_W-1:0] hi_m1, lo_m1;
  logic             samp_std, cfg_acc, tick, use_std, cap;
  logic [DATA_W-1:0] rx_word;

  // named internal events
  logic start_acc, ph_end, rise_ev, fall_ev, last_bit, frame_end;

  assign busy = (state != ST_IDLE);

  spi_smp_cfg #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .RST_PRE_M1(RST_PRE_M1),
    .RST_HI_M1(RST_HI_M1), .RST_LO_M1(RST_LO_M1)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy), .we(cfg_we),
    .pre_in(cfg_pre_m1), .hi_in(cfg_hi_m1), .lo_in(cfg_lo_m1), .samp_in(cfg_samp_std),
    .pre_m1(pre_m1), .hi_m1(hi_m1), .lo_m1(lo_m1), .samp_std(samp_std), .accept(cfg_acc)
  );

  spi_smp_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .pre_m1(pre_m1), .tick(tick)
  );

  assign use_std = use_std_edge(samp_std, pre_m1 == '0);

  always_comb begin
    case (state)
      ST_LEAD: ph_lim = PH_W'(hi_m1) + PH_W'(lo_m1) + PH_W'(1);
      ST_HIGH: ph_lim = PH_W'(hi_m1);
      default: ph_lim = PH_W'(lo_m1);
    endcase
  end

  assign start_acc = start && (state == ST_IDLE);
  assign ph_end    = tick && (ph_cnt == ph_lim);
  assign rise_ev   = ph_end && (state == ST_LEAD || state == ST_LOW);
  assign fall_ev   = ph_end && (state == ST_HIGH);
  assign last_bit  = (bit_cnt == BIT_W'(DATA_W - 1));
  assign frame_end = ph_end && (state == ST_TAIL);

  spi_smp_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .load_data(tx_data),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .use_std(use_std), .miso(miso),
    .mosi(mosi), .rx_word(rx_word), .cap(cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ph_cnt  <= '0;
      bit_cnt <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        state   <= ST_LEAD;
        cs_n    <= 1'b0;
        ph_cnt  <= '0;
        bit_cnt <= '0;
      end else if (tick) begin
        ph_cnt <= ph_end ? '0 : ph_cnt + PH_W'(1);
        if (ph_end) begin
          case (state)
            ST_LEAD, ST_LOW: begin
              state <= ST_HIGH;
              sclk  <= 1'b1;
            end
            ST_HIGH: begin
              sclk    <= 1'b0;
              bit_cnt <= bit_cnt + BIT_W'(1);
              state   <= last_bit ? ST_TAIL : ST_LOW;
            end
            ST_TAIL: begin
              state   <= ST_IDLE;
              cs_n    <= 1'b1;
              done    <= 1'b1;
              rx_data <= rx_word;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R3: clock only toggles inside a frame
  assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R10: done lasts a single cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done appears with chip select released and engine idle
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));

  // R11: a start during a frame does not disturb it
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !frame_end) |=> busy);

  // R9: configuration is never accepted while a frame runs
  assert_cfg_idle_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_acc |-> !busy);

endmodule

// File: tb/tb_spi_smp_master.sv
module tb_spi_smp_master;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] rx;
    logic [7:0] mo;
    int lead;
    int hi;
    int tail;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_samp_std = 0, start = 0;
  logic [12:0] cfg_pre_m1 = '0;
  logic [5:0]  cfg_hi_m1 = '0, cfg_lo_m1 = '0;
  logic [7:0]  tx_data = '0;
  logic        busy, done, cs_n, sclk, mosi;
  logic        miso = 0;
  logic [7:0]  rx_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  exp_t sb_q[$];

  // slave model
  logic [7:0]  sbyte = 8'h00;
  int          dly = 0;
  logic        cs_d = 1, sclk_d = 0;
  int          sidx = 0;
  logic [31:0] pv = '0, pb = '0;
  logic [7:0]  mosi_cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_smp_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pre_m1(cfg_pre_m1),
    .cfg_hi_m1(cfg_hi_m1), .cfg_lo_m1(cfg_lo_m1), .cfg_samp_std(cfg_samp_std),
    .start(start), .tx_data(tx_data), .busy(busy), .done(done), .rx_data(rx_data),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Slave: drives its next bit d clocks after it sees cs fall or sclk fall
  always @(posedge clk) begin : slave
    logic ev, bv;
    ev = 1'b0;
    bv = 1'b0;
    if (cs_d && !cs_n) begin
      ev = 1'b1; bv = sbyte[7]; sidx <= 6;
    end else if (!cs_n && sclk_d && !sclk && sidx >= 0) begin
      ev = 1'b1; bv = sbyte[sidx]; sidx <= sidx - 1;
    end
    pv <= {pv[30:0], ev};
    pb <= {pb[30:0], bv};
    if (dly == 0) begin
      if (ev) miso <= bv;
    end else if (pv[dly-1]) begin
      miso <= pb[dly-1];
    end
    if (!cs_n && !sclk_d && sclk) mosi_cap <= {mosi_cap[6:0], mosi};
    cs_d   <= cs_n;
    sclk_d <= sclk;
  end

  // Monitor: measures each frame and compares against the scoreboard
  int  m_lead = 0, m_hi = 0, m_tail = 0, m_rises = 0;
  logic m_prev = 0;
  bit  chk_done_low = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_done_low) begin
        chk(!done, "R10 done single cycle", int'(done), 0);
        chk_done_low = 0;
      end
      if (!cs_n) begin
        if (sclk && !m_prev) m_rises++;
        if (!sclk && m_rises == 0) m_lead++;
        if (sclk && m_rises == 1) m_hi++;
        if (!sclk && m_rises == 8) m_tail++;
      end
      m_prev = sclk;
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(0, "R11 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(rx_data == e.rx, "R5/R6 rx_data", int'(rx_data), int'(e.rx));
          chk(mosi_cap == e.mo, "R4 mosi word", int'(mosi_cap), int'(e.mo));
          chk(m_rises == 8, "R3 rising edge count", m_rises, 8);
          chk(m_lead == e.lead, "R3 cs lead time", m_lead, e.lead);
          chk(m_hi == e.hi, "R2 high width", m_hi, e.hi);
          chk(m_tail == e.tail, "R10 tail time", m_tail, e.tail);
          chk(cs_n && !busy, "R10 cs_n high busy low at done", int'({cs_n, busy}), 2);
        end
        chk_done_low = 1;
        m_lead = 0; m_hi = 0; m_tail = 0; m_rises = 0;
      end
    end
  end

  // Driver: pushes expectations, drives configuration and start.
  // mid: 0 none, 1 config write during frame, 2 extra start during frame
  task automatic run_xfer(input int pre, input int hi, input int lo, input bit std,
                          input bit wr, input bit same, input logic [7:0] sb,
                          input logic [7:0] tx, input int d, input int mid);
    exp_t e;
    int p, h, l;
    bit effstd;
    p = pre + 1; h = hi + 1; l = lo + 1;
    effstd = std && (pre != 0);
    e.rx   = (effstd && d > p*l - 2) ? {sb[7], sb[7:1]} : sb;
    e.mo   = tx;
    e.lead = p * (h + l);
    e.hi   = p * h;
    e.tail = p * l;
    sb_q.push_back(e);
    sbyte = sb;
    dly   = d;
    @(negedge clk);
    if (wr) begin
      cfg_pre_m1 = 13'(pre); cfg_hi_m1 = 6'(hi); cfg_lo_m1 = 6'(lo); cfg_samp_std = std;
      cfg_we = 1;
      if (!same) begin
        @(negedge clk);
        cfg_we = 0;
      end
    end
    tx_data = tx;
    start = 1;
    @(negedge clk);
    start = 0; cfg_we = 0;
    repeat (5) @(negedge clk);
    if (mid == 1) begin
      cfg_pre_m1 = 13'd3; cfg_hi_m1 = 6'd0; cfg_lo_m1 = 6'd0; cfg_samp_std = ~std;
      cfg_we = 1;
      @(negedge clk);
      cfg_we = 0;
    end else if (mid == 2) begin
      tx_data = ~tx;
      start = 1;
      @(negedge clk);
      start = 0;
      chk(busy, "R11 busy held after ignored start", int'(busy), 1);
    end
    while (busy) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1, "R1 cs_n", int'(cs_n), 1);
    chk(sclk == 0, "R1 sclk", int'(sclk), 0);
    chk(mosi == 0, "R1 mosi", int'(mosi), 0);
    chk(busy == 0, "R1 busy", int'(busy), 0);
    chk(done == 0, "R1 done", int'(done), 0);
    chk(rx_data == 0, "R1 rx_data", int'(rx_data), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R7 default: P=2 H=1 L=1 delayed, delay 2 beats standard but not delayed
    run_xfer(1, 0, 0, 0, 0, 0, 8'hA5, 8'h3C, 2, 0);
    // R5 standard capture within margin
    run_xfer(1, 1, 1, 1, 1, 0, 8'h96, 8'hC3, 1, 0);
    // R5 standard capture beyond low phase: shifted by one
    run_xfer(1, 1, 1, 1, 1, 0, 8'h5B, 8'h81, 4, 0);
    // R6 delayed capture recovers the same slow slave
    run_xfer(1, 1, 1, 0, 1, 0, 8'h5B, 8'h7E, 4, 0);
    // R8 divide of one forces delayed capture
    run_xfer(0, 3, 3, 1, 1, 0, 8'hD2, 8'h11, 4, 0);
    // R2 uneven widths with prescaler 3
    run_xfer(2, 2, 4, 1, 1, 0, 8'h3A, 8'hE7, 2, 0);
    // R2 minimum everything
    run_xfer(0, 0, 0, 0, 1, 0, 8'hF0, 8'h0F, 0, 0);
    // R9 config write during frame ignored; next frame keeps P=2 H=3 L=2
    run_xfer(1, 2, 1, 1, 1, 0, 8'h69, 8'h24, 0, 1);
    run_xfer(1, 2, 1, 1, 0, 0, 8'hC6, 8'h9D, 0, 0);
    // R11 extra start during frame ignored
    run_xfer(1, 0, 1, 0, 1, 0, 8'h17, 8'hB4, 1, 2);
    // R9 config write in the same cycle as start governs that frame
    run_xfer(3, 1, 2, 1, 1, 1, 8'h8E, 8'h55, 3, 0);
    chk(sb_q.size() == 0, "R11 all frames completed", sb_q.size(), 0);
    finish_run();
  end
endmodule